// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block holds the fetch state of every hardware thread in a multithreaded front end. Each cycle it takes the block and unblock pulses of four downstream stages (decode, rename, execute, commit), redirect requests from commit and from decode, the commit-side flag that the reorder buffer is still flushing, request and response events from the instruction cache, and trap, quiesce and wake events. From these it updates each thread's state, its redirect PC pair and the tag of its outstanding cache request. It also reports whether the fetch stage as a whole has useful work.

Every thread has its own sticky stall flag per stage and its own state machine. The checks run in a fixed order. Thread inactivity comes first. A commit redirect follows, then the flush hold, then a decode redirect, then the stall test, and last the ordinary progress transitions. The instruction cache echoes the request tag with each response. A squash changes the tag, so a response that arrives after a squash no longer matches and is discarded. State codes on `threadState`, four bits per thread, are: Running 0, Idle 1, Blocked 2, Squashing 3, WaitResponse 4, WaitRetry 5, AccessComplete 6, TrapPending 7, QuiescePending 8.

Top module: `fetch_thread_ctrl`

## Requirements
- R1: After reset every thread is in Running (code 0), its PC is RESET_PC, its next PC is RESET_PC+4 and its request tag is 0. The state codes are Running 0, Idle 1, Blocked 2, Squashing 3, WaitResponse 4, WaitRetry 5, AccessComplete 6, TrapPending 7, QuiescePending 8.
- R2: Each thread has one sticky stall flag per stage. Bit s of a thread's 4-bit group is decode for s=0, rename for 1, execute for 2 and commit for 3. A block pulse sets the flag and an unblock pulse clears it. If both arrive in the same cycle, the block wins. A thread counts as stalled when any of its flags, updated with this cycle's pulses, is set, or when the context-switch input is high.
- R3: A commit redirect to an active thread overrides every other input. It loads the PC with the supplied address and the next PC with that address plus 4, and the thread enters Squashing from any state. Other threads are not affected.
- R4: Without a commit redirect, the reorder-buffer flush flag puts or keeps the thread in Squashing. It takes precedence over a decode redirect in the same cycle, and that decode redirect does not change the PC.
- R5: A decode redirect loads the PC with its address and the next PC with that address plus 4, and moves the thread to Squashing, but only when the thread is not already in Squashing. Otherwise the redirect is ignored.
- R6: A thread's tag increments on every redirect that takes effect. It also increments when the thread leaves WaitResponse or WaitRetry for any reason other than a matched response. A response acts only when its thread index and tag equal the thread's current values and that thread is in WaitResponse. Any other response has no effect.
- R7: A stalled thread in Running, Idle, Blocked, Squashing or AccessComplete moves to Blocked. WaitResponse, WaitRetry, TrapPending and QuiescePending are held despite a stall.
- R8: With no redirect, flush or stall, a thread in Blocked, Squashing or Idle returns to Running in the next cycle.
- R9: A matched response moves the thread to Blocked if it is stalled, or to AccessComplete if not. AccessComplete lasts one cycle and then becomes Running.
- R10: In Running, a request issue with acknowledge enters WaitResponse, and an issue without acknowledge enters WaitRetry. A retry grant moves WaitRetry to WaitResponse.
- R11: In Running, a trap request enters TrapPending, and otherwise a quiesce request enters QuiescePending. Trap takes precedence over quiesce, and both take precedence over a request issue. A wake returns either state to Running.
- R12: A thread whose active input is low goes to Idle and ignores all other events, including redirects.
- R13: `stageActive` is high in the same cycle exactly when at least one active thread is in Running, Squashing or AccessComplete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| threadActive | input | NUM_THREADS | Per-thread active enable |
| stageBlock | input | 4*NUM_THREADS | Block pulses, 4 bits per thread (decode, rename, execute, commit) |
| stageUnblock | input | 4*NUM_THREADS | Unblock pulses, same layout |
| ctxSwitch | input | 1 | Context switch in progress (stalls all threads) |
| cmtSquash | input | NUM_THREADS | Commit redirect request |
| cmtPc | input | PC_W*NUM_THREADS | Commit redirect address per thread |
| robSquashing | input | NUM_THREADS | Reorder buffer still flushing |
| decSquash | input | NUM_THREADS | Decode redirect request |
| decPc | input | PC_W*NUM_THREADS | Decode redirect address per thread |
| reqIssue | input | NUM_THREADS | Fetch issues a cache request |
| reqAck | input | NUM_THREADS | Cache accepted the issued request |
| retryAck | input | NUM_THREADS | Cache accepted a retried request |
| trapReq | input | NUM_THREADS | Trap pending request |
| quiesceReq | input | NUM_THREADS | Quiesce request |
| wakeReq | input | NUM_THREADS | Wake from trap or quiesce |
| rspValid | input | 1 | Cache response valid |
| rspThread | input | TID_W | Thread index of the response |
| rspTag | input | TAG_W | Tag echoed with the response |
| threadState | output | 4*NUM_THREADS | State code per thread |
| fetchPc | output | PC_W*NUM_THREADS | Redirect PC per thread |
| nextPc | output | PC_W*NUM_THREADS | Redirect next PC per thread |
| reqTag | output | TAG_W*NUM_THREADS | Current request tag per thread |
| stageActive | output | 1 | Fetch stage has a thread able to make progress |

## Verification
The state of every thread is visible on `threadState` one clock after the event that changed it, so a wrong priority or a missed transition shows up at the ports on the next cycle. A stall flag that is wrongly set or cleared stays hidden until the thread reaches a state that may be blocked. The stimulus therefore places the pulses in cache-wait and trap states and checks that the state flips once the thread leaves them. A stale tag only shows when a late response is accepted or a fresh one is refused, so responses are sent with old and current tags right after each kind of squash.

// File: rtl/fts_pkg.sv
package fts_pkg;

  typedef enum logic [3:0] {
    ST_RUNNING      = 4'd0,
    ST_IDLE         = 4'd1,
    ST_BLOCKED      = 4'd2,
    ST_SQUASHING    = 4'd3,
    ST_WAIT_RSP     = 4'd4,
    ST_WAIT_RETRY   = 4'd5,
    ST_ACCESS_DONE  = 4'd6,
    ST_TRAP_PEND    = 4'd7,
    ST_QUIESCE_PEND = 4'd8
  } thrState_e;

  localparam int STAGE_CNT = 4;
  localparam int STATE_W   = 4;

  // strobes from the per-thread control to its datapath
  typedef struct packed {
    logic loadCmt;
    logic loadDec;
    logic bumpTag;
  } dpStrobe_t;

endpackage

// File: rtl/fts_stall_flags.sv
module fts_stall_flags #(
  parameter int STAGES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [STAGES-1:0] blockIn,
  input  logic [STAGES-1:0] unblockIn,
  input  logic              ctxSwitch,
  output logic              stalled
);

  logic [STAGES-1:0] flagsQ;
  logic [STAGES-1:0] flagsNext;

  // a block pulse wins over an unblock pulse in the same cycle
  always_comb begin
    flagsNext = (flagsQ & ~unblockIn) | blockIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) flagsQ <= '0;
    else       flagsQ <= flagsNext;
  end

  assign stalled = (|flagsNext) | ctxSwitch;

  p_block_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    (blockIn != '0) |=> ((flagsQ & $past(blockIn)) == $past(blockIn)));

  p_unblock_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((unblockIn & ~blockIn) != '0) |=> ((flagsQ & $past(unblockIn & ~blockIn)) == '0));

endmodule

// File: rtl/fts_thread_dp.sv
module fts_thread_dp
  import fts_pkg::*;
#(
  parameter int          PC_W     = 32,
  parameter int          TAG_W    = 4,
  parameter logic [31:0] RESET_PC = 32'h100
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobes,
  input  logic [PC_W-1:0]  cmtPcIn,
  input  logic [PC_W-1:0]  decPcIn,
  output logic [PC_W-1:0]  pcQ,
  output logic [PC_W-1:0]  nextPcQ,
  output logic [TAG_W-1:0] tagQ
);

  localparam logic [PC_W-1:0] INST_BYTES = PC_W'(4);
  localparam logic [PC_W-1:0] PC_INIT    = PC_W'(RESET_PC);

  logic [PC_W-1:0] redirectPc;

  always_comb begin
    redirectPc = strobes.loadCmt ? cmtPcIn : decPcIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ     <= PC_INIT;
      nextPcQ <= PC_INIT + INST_BYTES;
      tagQ    <= '0;
    end else begin
      if (strobes.loadCmt || strobes.loadDec) begin
        pcQ     <= redirectPc;
        nextPcQ <= redirectPc + INST_BYTES;
      end
      if (strobes.bumpTag) tagQ <= tagQ + TAG_W'(1);
    end
  end

  p_cmt_redirect_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadCmt |=> (pcQ == $past(cmtPcIn)) && (nextPcQ == $past(cmtPcIn) + INST_BYTES));

  p_dec_redirect_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadDec && !strobes.loadCmt) |=> (pcQ == $past(decPcIn)));

  p_tag_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.bumpTag |=> (tagQ == TAG_W'($past(tagQ) + TAG_W'(1))));

endmodule

// File: rtl/fts_thread_ctrl.sv
module fts_thread_ctrl
  import fts_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int TID_W = 1,
  parameter int TID   = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             active,
  input  logic             stalled,
  input  logic             cmtSquash,
  input  logic             robSquashing,
  input  logic             decSquash,
  input  logic             reqIssue,
  input  logic             reqAck,
  input  logic             retryAck,
  input  logic             trapReq,
  input  logic             quiesceReq,
  input  logic             wakeReq,
  input  logic             rspValid,
  input  logic [TID_W-1:0] rspThread,
  input  logic [TAG_W-1:0] rspTag,
  input  logic [TAG_W-1:0] curTag,
  output thrState_e        stateQ,
  output dpStrobe_t        strobes
);

  localparam logic [TID_W-1:0] MY_ID = TID_W'(TID);

  thrState_e stateD;
  logic      rspForMe;
  logic      rspHit;
  logic      inWait;
  logic      nextInWait;
  logic      mayBlock;
  logic      redirect;

  always_comb begin
    rspForMe = rspValid && (rspThread == MY_ID) && (rspTag == curTag);
    rspHit   = rspForMe && (stateQ == ST_WAIT_RSP);
    inWait   = (stateQ == ST_WAIT_RSP) || (stateQ == ST_WAIT_RETRY);
    mayBlock = (stateQ == ST_RUNNING) || (stateQ == ST_IDLE) ||
               (stateQ == ST_BLOCKED) || (stateQ == ST_SQUASHING) ||
               (stateQ == ST_ACCESS_DONE);
  end

  always_comb begin
    stateD          = stateQ;
    strobes.loadCmt = 1'b0;
    strobes.loadDec = 1'b0;
    if (!active) begin
      stateD = ST_IDLE;
    end else if (cmtSquash) begin
      strobes.loadCmt = 1'b1;
      stateD          = ST_SQUASHING;
    end else if (robSquashing) begin
      stateD = ST_SQUASHING;
    end else if (decSquash && (stateQ != ST_SQUASHING)) begin
      strobes.loadDec = 1'b1;
      stateD          = ST_SQUASHING;
    end else if (stalled && mayBlock) begin
      stateD = ST_BLOCKED;
    end else begin
      unique case (stateQ)
        ST_IDLE, ST_BLOCKED, ST_SQUASHING, ST_ACCESS_DONE: stateD = ST_RUNNING;
        ST_RUNNING: begin
          if (trapReq)         stateD = ST_TRAP_PEND;
          else if (quiesceReq) stateD = ST_QUIESCE_PEND;
          else if (reqIssue)   stateD = reqAck ? ST_WAIT_RSP : ST_WAIT_RETRY;
        end
        ST_WAIT_RETRY: if (retryAck) stateD = ST_WAIT_RSP;
        ST_WAIT_RSP:   if (rspHit) stateD = stalled ? ST_BLOCKED : ST_ACCESS_DONE;
        ST_TRAP_PEND, ST_QUIESCE_PEND: if (wakeReq) stateD = ST_RUNNING;
        default: stateD = ST_RUNNING;
      endcase
    end
  end

  // tag moves on any redirect and on abandoning an outstanding request
  always_comb begin
    redirect        = strobes.loadCmt || strobes.loadDec;
    nextInWait      = (stateD == ST_WAIT_RSP) || (stateD == ST_WAIT_RETRY);
    strobes.bumpTag = redirect || (inWait && !nextInWait && !rspHit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_RUNNING;
    else       stateQ <= stateD;
  end

  p_cmt_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    (active && cmtSquash) |=> (stateQ == ST_SQUASHING));

  p_flush_holds_r4: assert property (@(posedge clk) disable iff (!rstN)
    (active && !cmtSquash && robSquashing) |=> (stateQ == ST_SQUASHING));

  p_wait_kept_r7: assert property (@(posedge clk) disable iff (!rstN)
    (active && (stateQ == ST_WAIT_RSP) && !cmtSquash && !robSquashing && !decSquash && !rspForMe)
      |=> (stateQ == ST_WAIT_RSP));

  p_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> (stateQ == ST_IDLE));

  p_done_brief_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((stateQ == ST_ACCESS_DONE) && active && !cmtSquash && !robSquashing && !decSquash && !stalled)
      |=> (stateQ == ST_RUNNING));

endmodule

// File: rtl/fetch_thread_ctrl.sv
module fetch_thread_ctrl
  import fts_pkg::*;
#(
  parameter int          NUM_THREADS = 2,
  parameter int          PC_W        = 32,
  parameter int          TAG_W       = 4,
  parameter logic [31:0] RESET_PC    = 32'h100,
  localparam int         TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_THREADS-1:0]         threadActive,
  input  logic [NUM_THREADS*4-1:0]       stageBlock,
  input  logic [NUM_THREADS*4-1:0]       stageUnblock,
  input  logic                           ctxSwitch,
  input  logic [NUM_THREADS-1:0]         cmtSquash,
  input  logic [NUM_THREADS*PC_W-1:0]    cmtPc,
  input  logic [NUM_THREADS-1:0]         robSquashing,
  input  logic [NUM_THREADS-1:0]         decSquash,
  input  logic [NUM_THREADS*PC_W-1:0]    decPc,
  input  logic [NUM_THREADS-1:0]         reqIssue,
  input  logic [NUM_THREADS-1:0]         reqAck,
  input  logic [NUM_THREADS-1:0]         retryAck,
  input  logic [NUM_THREADS-1:0]         trapReq,
  input  logic [NUM_THREADS-1:0]         quiesceReq,
  input  logic [NUM_THREADS-1:0]         wakeReq,
  input  logic                           rspValid,
  input  logic [TID_W-1:0]               rspThread,
  input  logic [TAG_W-1:0]               rspTag,
  output logic [NUM_THREADS*4-1:0]       threadState,
  output logic [NUM_THREADS*PC_W-1:0]    fetchPc,
  output logic [NUM_THREADS*PC_W-1:0]    nextPc,
  output logic [NUM_THREADS*TAG_W-1:0]   reqTag,
  output logic                           stageActive
);

  thrState_e              stateVec [NUM_THREADS];
  logic [NUM_THREADS-1:0] canWork;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
    logic             stalled;
    dpStrobe_t        strobes;
    logic [TAG_W-1:0] tag;

    fts_stall_flags #(.STAGES(STAGE_CNT)) stall_i (
      .clk       (clk),
      .rstN      (rstN),
      .blockIn   (stageBlock[t*STAGE_CNT +: STAGE_CNT]),
      .unblockIn (stageUnblock[t*STAGE_CNT +: STAGE_CNT]),
      .ctxSwitch (ctxSwitch),
      .stalled   (stalled)
    );

    fts_thread_ctrl #(.TAG_W(TAG_W), .TID_W(TID_W), .TID(t)) ctrl_i (
      .clk          (clk),
      .rstN         (rstN),
      .active       (threadActive[t]),
      .stalled      (stalled),
      .cmtSquash    (cmtSquash[t]),
      .robSquashing (robSquashing[t]),
      .decSquash    (decSquash[t]),
      .reqIssue     (reqIssue[t]),
      .reqAck       (reqAck[t]),
      .retryAck     (retryAck[t]),
      .trapReq      (trapReq[t]),
      .quiesceReq   (quiesceReq[t]),
      .wakeReq      (wakeReq[t]),
      .rspValid     (rspValid),
      .rspThread    (rspThread),
      .rspTag       (rspTag),
      .curTag       (tag),
      .stateQ       (stateVec[t]),
      .strobes      (strobes)
    );

    fts_thread_dp #(.PC_W(PC_W), .TAG_W(TAG_W), .RESET_PC(RESET_PC)) dp_i (
      .clk     (clk),
      .rstN    (rstN),
      .strobes (strobes),
      .cmtPcIn (cmtPc[t*PC_W +: PC_W]),
      .decPcIn (decPc[t*PC_W +: PC_W]),
      .pcQ     (fetchPc[t*PC_W +: PC_W]),
      .nextPcQ (nextPc[t*PC_W +: PC_W]),
      .tagQ    (tag)
    );

    assign reqTag[t*TAG_W +: TAG_W]  = tag;
    assign threadState[t*4 +: 4]     = stateVec[t];
    assign canWork[t] = threadActive[t] &&
                        ((stateVec[t] == ST_RUNNING) || (stateVec[t] == ST_SQUASHING) ||
                         (stateVec[t] == ST_ACCESS_DONE));
  end

  assign stageActive = |canWork;

endmodule

// File: tb/fetch_thread_ctrl_tb.sv
`timescale 1ns/1ps
module fetch_thread_ctrl_tb_top;

  localparam int NT    = 2;
  localparam int PC_W  = 32;
  localparam int TAG_W = 4;

  typedef struct packed {
    logic [3:0] blk;
    logic [3:0] unb;
    logic       ctx;
    logic       cmt;
    logic       rob;
    logic       dec;
    logic       iss;
    logic       ack;
    logic       rty;
    logic       rsp;
    logic [3:0] rtag;
    logic       trp;
    logic       qui;
    logic       wk;
    logic [3:0] est;
    logic [3:0] etag;
    logic [1:0] sel;
  } vec_t;

  function automatic vec_t v(input logic [3:0] blk, input logic [3:0] unb,
                             input logic ctx, input logic cmt, input logic rob,
                             input logic dec, input logic iss, input logic ack,
                             input logic rty, input logic rsp, input logic [3:0] rtag,
                             input logic trp, input logic qui, input logic wk,
                             input logic [3:0] est, input logic [3:0] etag,
                             input logic [1:0] sel);
    vec_t r;
    r = '{blk, unb, ctx, cmt, rob, dec, iss, ack, rty, rsp, rtag, trp, qui, wk, est, etag, sel};
    return r;
  endfunction

  localparam int NV = 49;
  //        blk   unb   ctx cmt rob dec iss ack rty rsp rtag trp qui wk  est  etag sel
  localparam vec_t TBL [NV] = '{
    v(4'h0,4'h0,0,0,0,0,1,1,0,0,4'd0,0,0,0,4'd4,4'd0,2'd0), // R10 issue acked
    v(4'h0,4'h0,0,0,0,0,0,0,0,1,4'd0,0,0,0,4'd6,4'd0,2'd0), // R9 matched rsp
    v(4'h0,4'h0,0,0,0,0,0,0,0,0,4'd0,0,0,0,4'd0,4'd0,2'd0), // R9 done->running
    v(4'h0,4'h0,0,0,0,0,1,0,0,0,4'd0,0,0,0,4'd5,4'd0,2'd0), // R10 refused
    v(4'h0,4'h0,0,0,0,0,0,0,1,0,4'd0,0,0,0,4'd4,4'd0,2'd0), // R10 retry grant
    v(4'h1,4'h0,0,0,0,0,0,0,0,0,4'd0,0,0,0,4'd4,4'd0,2'd0), // R7 wait held
    v(4'h0,4'h0,0,0,0,0,0,0,0,1,4'd0,0,0,0,4'd2,4'd0,2'd0), // R9 rsp while stalled
    v(4'h0,4'h0,0,0,0,0,0,0,0,0,4'd0,0,0,0,4'd2,4'd0,2'd0), // R2 sticky
    v(4'h0,4'h1,0,0,0,0,0,0,0,0,4'd0,0,0,0,4'd0,4'd0,2'd0), // R8 unblocked
    v(4'h0,4'h0,0,0,0,0,1,1,0,0,4'd0,0,0,0,4'd4,4'd0,2'd0), // R10
    v(4'h0,4'h0,0,1,0,0,0,0,0,0,4'd0,0,0,0,4'd3,4'd1,2'd1), // R3 squash in wait
    v(4'h0,4'h0,0,0,1,0,0,0,0,1,4'd0,0,0,0,4'd3,4'd1,2'd0), // R6 late rsp, R4
    v(4'h0,4'h0,0,0,0,0,0,0,0,0,4'd0,0,0,0,4'd0,4'd1,2'd0), // R8
    v(4'h0,4'h0,0,0,0,0,1,1,0,0,4'd0,0,0,0,4'd4,4'd1,2'd0), // R10
    v(4'h0,4'h0,0,0,0,0,0,0,0,1,4'd0,0,0,0,4'd4,4'd1,2'd0), // R6 stale tag
    v(4'h0,4'h0,0,0,0,0,0,0,0,1,4'd1,0,0,0,4'd6,4'd1,2'd0), // R6 fresh tag
    v(4'h0,4'h0,0,0,0,0,0,0,0,0,4'd0,0,0,0,4'd0,4'd1,2'd0), // R9
    v(4'h0,4'h0,0,0,0,1,0,0,0,0,4'd0,0,0,0,4'd3,4'd2,2'd2), // R5 dec redirect
    v(4'h0,4'h0,0,0,0,1,0,0,0,0,4'd0,0,0,0,4'd0,4'd2,2'd0), // R5 ignored
    v(4'h0,4'h0,0,1,0,1,0,0,0,0,4'd0,0,0,0,4'd3,4'd3,2'd1), // R3 over decode
    v(4'h0,4'h0,0,0,1,0,0,0,0,0,4'd0,0,0,0,4'd3,4'd3,2'd0), // R4
    v(4'h0,4'h0,0,0,1,1,0,0,0,0,4'd0,0,0,0,4'd3,4'd3,2'd0), // R4 over decode
    v(4'h0,4'h0,0,0,0,0,0,0,0,0,4'd0,0,0,0,4'd0,4'd3,2'd0), // R8
    v(4'h0,4'h0,1,0,0,0,0,0,0,0,4'd0,0,0,0,4'd2,4'd3,2'd0), // R2 ctx switch
    v(4'h0,4'h0,0,0,0,0,0,0,0,0,4'd0,0,0,0,4'd0,4'd3,2'd0), // R2
    v(4'hA,4'h0,0,0,0,0,0,0,0,0,4'd0,0,0,0,4'd2,4'd3,2'd0), // R2 two flags
    v(4'h0,4'h8,0,0,0,0,0,0,0,0,4'd0,0,0,0,4'd2,4'd3,2'd0), // R2 one left
    v(4'h0,4'h2,0,0,0,0,0,0,0,0,4'd0,0,0,0,4'd0,4'd3,2'd0), // R2 all clear
    v(4'h0,4'h0,0,0,0,0,0,0,0,0,4'd0,1,0,0,4'd7,4'd3,2'd0), // R11 trap
    v(4'h1,4'h0,0,0,0,0,0,0,0,0,4'd0,0,0,0,4'd7,4'd3,2'd0), // R7 trap held
    v(4'h0,4'h0,0,0,0,0,0,0,0,0,4'd0,0,0,1,4'd0,4'd3,2'd0), // R11 wake
    v(4'h0,4'h0,0,0,0,0,0,0,0,0,4'd0,0,0,0,4'd2,4'd3,2'd0), // R7 stall applies
    v(4'h0,4'h1,0,0,0,0,0,0,0,0,4'd0,0,0,0,4'd0,4'd3,2'd0), // R8
    v(4'h0,4'h0,0,0,0,0,1,1,0,0,4'd0,0,1,0,4'd8,4'd3,2'd0), // R11 quiesce over issue
    v(4'h0,4'h0,0,1,0,0,0,0,0,0,4'd0,0,0,0,4'd3,4'd4,2'd1), // R3 from quiesce
    v(4'h0,4'h0,0,0,0,0,0,0,0,0,4'd0,0,0,0,4'd0,4'd4,2'd0), // R8
    v(4'h0,4'h0,0,0,0,0,1,1,0,0,4'd0,0,0,0,4'd4,4'd4,2'd0), // R10
    v(4'h0,4'h0,0,0,1,0,0,0,0,0,4'd0,0,0,0,4'd3,4'd5,2'd0), // R6 flush abandons
    v(4'h0,4'h0,0,0,0,0,0,0,0,0,4'd0,0,0,0,4'd0,4'd5,2'd0), // R8
    v(4'h0,4'h0,0,0,0,0,1,0,0,0,4'd0,0,0,0,4'd5,4'd5,2'd0), // R10
    v(4'h0,4'h0,0,0,0,1,0,0,0,0,4'd0,0,0,0,4'd3,4'd6,2'd2), // R6 dec in retry
    v(4'h0,4'h0,0,0,0,0,0,0,0,0,4'd0,0,0,0,4'd0,4'd6,2'd0), // R8
    v(4'h0,4'h0,0,0,0,0,0,0,0,1,4'd6,0,0,0,4'd0,4'd6,2'd0), // R6 rsp when running
    v(4'h0,4'h0,0,0,0,0,1,1,0,0,4'd0,0,0,0,4'd4,4'd6,2'd0), // R10
    v(4'h0,4'h0,0,0,0,0,0,0,0,1,4'd6,0,0,0,4'd6,4'd6,2'd0), // R9
    v(4'h4,4'h0,0,0,0,0,0,0,0,0,4'd0,0,0,0,4'd2,4'd6,2'd0), // R7 done blocked
    v(4'h0,4'h4,0,0,0,0,0,0,0,0,4'd0,0,0,0,4'd0,4'd6,2'd0), // R8
    v(4'h1,4'h1,0,0,0,0,0,0,0,0,4'd0,0,0,0,4'd2,4'd6,2'd0), // R2 block wins
    v(4'h0,4'h1,0,0,0,0,0,0,0,0,4'd0,0,0,0,4'd0,4'd6,2'd0)  // R2
  };

  logic                  clk = 1'b0;
  logic                  rstN;
  logic [NT-1:0]         threadActive;
  logic [NT*4-1:0]       stageBlock, stageUnblock;
  logic                  ctxSwitch;
  logic [NT-1:0]         cmtSquash, robSquashing, decSquash;
  logic [NT*PC_W-1:0]    cmtPc, decPc;
  logic [NT-1:0]         reqIssue, reqAck, retryAck, trapReq, quiesceReq, wakeReq;
  logic                  rspValid;
  logic [0:0]            rspThread;
  logic [TAG_W-1:0]      rspTag;
  logic [NT*4-1:0]       threadState;
  logic [NT*PC_W-1:0]    fetchPc, nextPc;
  logic [NT*TAG_W-1:0]   reqTag;
  logic                  stageActive;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 0;

  always #2.5 clk = ~clk;

  fetch_thread_ctrl #(.NUM_THREADS(NT), .PC_W(PC_W), .TAG_W(TAG_W), .RESET_PC(32'h100)) dut_i (
    .clk(clk), .rstN(rstN), .threadActive(threadActive),
    .stageBlock(stageBlock), .stageUnblock(stageUnblock), .ctxSwitch(ctxSwitch),
    .cmtSquash(cmtSquash), .cmtPc(cmtPc), .robSquashing(robSquashing),
    .decSquash(decSquash), .decPc(decPc), .reqIssue(reqIssue), .reqAck(reqAck),
    .retryAck(retryAck), .trapReq(trapReq), .quiesceReq(quiesceReq), .wakeReq(wakeReq),
    .rspValid(rspValid), .rspThread(rspThread), .rspTag(rspTag),
    .threadState(threadState), .fetchPc(fetchPc), .nextPc(nextPc), .reqTag(reqTag),
    .stageActive(stageActive)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clearIn();
    stageBlock = '0; stageUnblock = '0; ctxSwitch = 1'b0;
    cmtSquash = '0; robSquashing = '0; decSquash = '0;
    cmtPc = '0; decPc = '0;
    reqIssue = '0; reqAck = '0; retryAck = '0;
    trapReq = '0; quiesceReq = '0; wakeReq = '0;
    rspValid = 1'b0; rspThread = '0; rspTag = '0;
  endtask

  // inputs were set 1 ns after the previous edge; advance one edge and settle
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic [31:0] expPc;
    threadActive = 2'b11;
    clearIn();
    rstN = 1'b0;
    step(); step();
    rstN = 1'b1;
    #0;

    // R1 reset state
    chk("R1", "state0", threadState[3:0], 4'd0);
    chk("R1", "state1", threadState[7:4], 4'd0);
    chk("R1", "pc0", fetchPc[31:0], 32'h100);
    chk("R1", "npc0", nextPc[31:0], 32'h104);
    chk("R1", "tag0", reqTag[3:0], 4'd0);
    chk("R13", "active at reset", stageActive, 1'b1);

    expPc = 32'h100;
    for (int i = 0; i < NV; i++) begin
      clearIn();
      stageBlock[3:0]   = TBL[i].blk;
      stageUnblock[3:0] = TBL[i].unb;
      ctxSwitch         = TBL[i].ctx;
      cmtSquash[0]      = TBL[i].cmt;
      robSquashing[0]   = TBL[i].rob;
      decSquash[0]      = TBL[i].dec;
      reqIssue[0]       = TBL[i].iss;
      reqAck[0]         = TBL[i].ack;
      retryAck[0]       = TBL[i].rty;
      rspValid          = TBL[i].rsp;
      rspTag            = TBL[i].rtag;
      trapReq[0]        = TBL[i].trp;
      quiesceReq[0]     = TBL[i].qui;
      wakeReq[0]        = TBL[i].wk;
      cmtPc[31:0]       = 32'h1000 + 32'(i) * 16;
      decPc[31:0]       = 32'h2000 + 32'(i) * 16;
      if (TBL[i].sel == 2'd1) expPc = 32'h1000 + 32'(i) * 16;
      if (TBL[i].sel == 2'd2) expPc = 32'h2000 + 32'(i) * 16;
      step();
      chk($sformatf("R2-R11 vec %0d", i), "state0", threadState[3:0], TBL[i].est);
      chk($sformatf("R6 vec %0d", i), "tag0", reqTag[3:0], TBL[i].etag);
      chk($sformatf("R3/R5 vec %0d", i), "pc0", fetchPc[31:0], expPc);
      chk($sformatf("R3/R5 vec %0d", i), "npc0", nextPc[31:0], expPc + 32'd4);
    end

    // R3 other thread untouched through all of the above
    chk("R3", "state1 untouched", threadState[7:4], 4'd0);
    chk("R3", "pc1 untouched", fetchPc[63:32], 32'h100);

    // R12 inactive thread goes idle
    clearIn(); threadActive = 2'b01;
    step();
    chk("R12", "state1 idle", threadState[7:4], 4'd1);
    chk("R13", "active via thread0", stageActive, 1'b1);

    // R13 no worker left; R12 redirect to idle thread ignored
    clearIn(); reqIssue[0] = 1'b1; reqAck[0] = 1'b1;
    cmtSquash[1] = 1'b1; cmtPc[63:32] = 32'h3000;
    step();
    chk("R10", "state0 wait", threadState[3:0], 4'd4);
    chk("R12", "state1 stays idle", threadState[7:4], 4'd1);
    chk("R12", "pc1 unchanged", fetchPc[63:32], 32'h100);
    chk("R13", "inactive stage", stageActive, 1'b0);

    // R6 response with thread0 tag but thread index 1 is dropped
    clearIn(); rspValid = 1'b1; rspThread = 1'b1; rspTag = 4'd6;
    step();
    chk("R6", "wrong thread rsp", threadState[3:0], 4'd4);
    chk("R13", "still inactive", stageActive, 1'b0);

    clearIn(); rspValid = 1'b1; rspThread = 1'b0; rspTag = 4'd6;
    step();
    chk("R9", "state0 done", threadState[3:0], 4'd6);
    chk("R13", "active on done", stageActive, 1'b1);

    // R8 idle thread returns to running when enabled
    clearIn(); threadActive = 2'b11;
    step();
    chk("R8", "state1 running", threadState[7:4], 4'd0);
    chk("R9", "state0 running", threadState[3:0], 4'd0);

    // R3 commit redirect on thread1 only
    clearIn(); cmtSquash[1] = 1'b1; cmtPc[63:32] = 32'h4000; cmtPc[31:0] = 32'h5000;
    step();
    chk("R3", "state1 squashing", threadState[7:4], 4'd3);
    chk("R3", "pc1", fetchPc[63:32], 32'h4000);
    chk("R3", "npc1", nextPc[63:32], 32'h4004);
    chk("R6", "tag1", reqTag[7:4], 4'd1);
    chk("R3", "pc0 kept", fetchPc[31:0], expPc);

    // R13 thread0 blocked, thread1 idle -> inactive stage
    clearIn(); stageBlock[0] = 1'b1; threadActive = 2'b01;
    step();
    chk("R7", "state0 blocked", threadState[3:0], 4'd2);
    chk("R13", "no worker", stageActive, 1'b0);

    finish();
  end

endmodule